// File: doc/BRIEF.md
# Breakpoint Control Register Access Gate

This block decides what happens when software reads or writes one of the breakpoint control system registers. Each request carries its encoding fields, its access direction, and the exception level it was issued from. It is sampled together with the current trap controls, the implementation flags, the OS-lock state and the halting permission.

One clock edge after a request strobe, the block reports exactly one verdict. The verdict is one of: not addressed to this register group, undefined, trap to level 2, trap to level 3, debug halt, or carry out the access. A syndrome class code goes with the verdict.

The exception entry logic and the register file act on the verdict. Neither is part of this block.

Top module: `brk_ctrl_gate`

## Requirements
- R1: A request whose op0 is not 2, op1 is not 0, CRn is not 0 or op2 is not 5 yields `res_foreign` alone, with every other verdict bit low and `res_class` 0.
- R2: A matching request whose CRm index is not below `NUM_BP` yields `res_undef`, whatever the exception level.
- R3: A matching, in-range request from level 0 (`req_el` = 0) yields `res_undef`.
- R4: At level 1, the first check traps to level 2. It applies when level 2 is enabled and 64-bit, the fine-grained bit for the access direction is set, and either level 3 is absent or the fine-grain enable is set. The direction bit is `fgt_read` for reads and `fgt_write` for writes (`req_write` = 1).
- R5: At level 1, when R4 does not hold, the request traps to level 2 if level 2 is enabled and 64-bit and either `hyp_tde` or `hyp_tda` is set.
- R6: At level 1 after R4 and R5, and first at level 2, the request traps to level 3 when level 3 is present and 64-bit and `mon_tda` is set.
- R7: At levels 1 and 2 after the checks above, and first at level 3, the request halts when level 1 is 64-bit, the OS lock is clear, halting is allowed and `ext_tda` is set.
- R8: When no check above holds, the verdict is `res_access`. At level 2 the fine-grained and hypervisor bits have no effect. At level 3 the monitor bit has no effect either.
- R9: `res_class` is 0x18 on both trap verdicts and 0 on every other verdict.
- R10: `res_valid` and one verdict bit rise in the cycle after `req_valid` is sampled high. All verdict bits are low in a cycle after `req_valid` is sampled low.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_el | input | 2 | Issuing exception level, 0 to 3 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm, the breakpoint index |
| req_op2 | input | 3 | Encoding field op2 |
| fgt_read | input | 1 | Fine-grained read trap bit |
| fgt_write | input | 1 | Fine-grained write trap bit |
| fgt_en | input | 1 | Fine-grain enable from level 3 |
| hyp_tde | input | 1 | Hypervisor debug-exception routing bit |
| hyp_tda | input | 1 | Hypervisor debug-access trap bit |
| mon_tda | input | 1 | Monitor debug-access trap bit |
| ext_tda | input | 1 | External debugger access trap bit |
| el2_on | input | 1 | Level 2 enabled in the current security state |
| el2_64 | input | 1 | Level 2 runs 64-bit |
| el3_have | input | 1 | Level 3 implemented |
| el3_64 | input | 1 | Level 3 runs 64-bit |
| el1_64 | input | 1 | Level 1 runs 64-bit |
| os_lock | input | 1 | OS lock set |
| halt_ok | input | 1 | Halting allowed |
| res_valid | output | 1 | Verdict present |
| res_foreign | output | 1 | Not addressed to this register group |
| res_undef | output | 1 | Undefined |
| res_trap2 | output | 1 | Trap to level 2 |
| res_trap3 | output | 1 | Trap to level 3 |
| res_halt | output | 1 | Debug halt |
| res_access | output | 1 | Carry out the access |
| res_class | output | 6 | Syndrome class code |
| res_index | output | 4 | Breakpoint index of the verdict |

## Verification
The assertions assume that `req_el` is always a legal level and that every control input is a settled 0 or 1 whenever `req_valid` is high. They also assume the requester holds nothing between strobes, because each verdict depends only on the cycle it was sampled in. The stimulus drives every input at the falling edge from fully random bits, with the encoding forced to match three times in four, and leaves about one cycle in five idle. The behavioural model then predicts each verdict from the held copy of those inputs.

// File: rtl/brk_ctrl_gate.sv
module brk_ctrl_gate #(
  parameter int NUM_BP = 16,
  parameter logic [5:0] TRAP_CLASS = 6'h18,
  parameter logic [1:0] ENC_OP0 = 2'd2,
  parameter logic [2:0] ENC_OP1 = 3'd0,
  parameter logic [3:0] ENC_CRN = 4'd0,
  parameter logic [2:0] ENC_OP2 = 3'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_el,
  input  logic       req_write,
  input  logic [1:0] req_op0,
  input  logic [2:0] req_op1,
  input  logic [3:0] req_crn,
  input  logic [3:0] req_crm,
  input  logic [2:0] req_op2,
  input  logic       fgt_read,
  input  logic       fgt_write,
  input  logic       fgt_en,
  input  logic       hyp_tde,
  input  logic       hyp_tda,
  input  logic       mon_tda,
  input  logic       ext_tda,
  input  logic       el2_on,
  input  logic       el2_64,
  input  logic       el3_have,
  input  logic       el3_64,
  input  logic       el1_64,
  input  logic       os_lock,
  input  logic       halt_ok,
  output logic       res_valid,
  output logic       res_foreign,
  output logic       res_undef,
  output logic       res_trap2,
  output logic       res_trap3,
  output logic       res_halt,
  output logic       res_access,
  output logic [5:0] res_class,
  output logic [3:0] res_index
);

  localparam logic [4:0] BP_LIMIT = 5'(NUM_BP);

  wire enc_hit  = (req_op0 == ENC_OP0) && (req_op1 == ENC_OP1) &&
                  (req_crn == ENC_CRN) && (req_op2 == ENC_OP2);
  wire idx_ok   = {1'b0, req_crm} < BP_LIMIT;
  wire el2_live = el2_on && el2_64;
  wire fg_bit   = req_write ? fgt_write : fgt_read;
  wire fg_hit   = el2_live && fg_bit && (!el3_have || fgt_en);
  wire hyp_hit  = el2_live && (hyp_tde || hyp_tda);
  wire mon_hit  = el3_have && el3_64 && mon_tda;
  wire halt_hit = el1_64 && !os_lock && halt_ok && ext_tda;

  // verdict order: foreign, undef, trap2, trap3, halt, access
  logic [5:0] verdict;

  always_comb begin
    verdict = 6'b0;
    if (!enc_hit)                   verdict[5] = 1'b1;
    else if (!idx_ok)               verdict[4] = 1'b1;
    else begin
      unique case (req_el)
        2'd0: verdict[4] = 1'b1;
        2'd1: begin
          if (fg_hit || hyp_hit)    verdict[3] = 1'b1;
          else if (mon_hit)         verdict[2] = 1'b1;
          else if (halt_hit)        verdict[1] = 1'b1;
          else                      verdict[0] = 1'b1;
        end
        2'd2: begin
          if (mon_hit)              verdict[2] = 1'b1;
          else if (halt_hit)        verdict[1] = 1'b1;
          else                      verdict[0] = 1'b1;
        end
        default: begin
          if (halt_hit)             verdict[1] = 1'b1;
          else                      verdict[0] = 1'b1;
        end
      endcase
    end
  end

  logic [5:0] verdict_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      verdict_q <= '0;
      res_class <= '0;
      res_index <= '0;
    end else begin
      res_valid <= req_valid;
      verdict_q <= req_valid ? verdict : 6'b0;
      res_class <= (req_valid && (verdict[3] || verdict[2])) ? TRAP_CLASS : 6'd0;
      res_index <= req_valid ? req_crm : 4'd0;
    end
  end

  assign {res_foreign, res_undef, res_trap2, res_trap3, res_halt, res_access} = verdict_q;

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (res_valid && $onehot({res_foreign, res_undef, res_trap2, res_trap3, res_halt, res_access})));

  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!res_valid && !res_foreign && !res_undef && !res_trap2 &&
                    !res_trap3 && !res_halt && !res_access));

  a_r1_foreign_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op0 != ENC_OP0)) |=> (res_foreign && res_class == 6'd0));

  a_r3_el0_undef: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && enc_hit && req_el == 2'd0) |=> res_undef);

  a_r8_el3_no_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && enc_hit && idx_ok && req_el == 2'd3) |=> (res_halt || res_access));

  a_r9_class: assert property (@(posedge clk) disable iff (!rst_n)
    (res_trap2 || res_trap3) |-> res_class == TRAP_CLASS);

  a_r9_class_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_trap2 && !res_trap3) |-> res_class == 6'd0);

endmodule

// File: tb/brk_ctrl_gate_test.sv
module brk_ctrl_gate_test;
  localparam int NBP = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [1:0] req_el = 0, req_op0 = 0;
  logic [2:0] req_op1 = 0, req_op2 = 0;
  logic [3:0] req_crn = 0, req_crm = 0;
  logic fgt_read = 0, fgt_write = 0, fgt_en = 0, hyp_tde = 0, hyp_tda = 0;
  logic mon_tda = 0, ext_tda = 0, el2_on = 0, el2_64 = 0, el3_have = 0;
  logic el3_64 = 0, el1_64 = 0, os_lock = 0, halt_ok = 0;
  logic res_valid, res_foreign, res_undef, res_trap2, res_trap3, res_halt, res_access;
  logic [5:0] res_class;
  logic [3:0] res_index;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  brk_ctrl_gate #(.NUM_BP(NBP)) uut (.*);

  // expected verdict bits in order foreign, undef, trap2, trap3, halt, access
  logic [5:0] exp_v;
  logic       exp_valid;
  logic [5:0] exp_class;
  logic [3:0] exp_idx;
  string      exp_tag;

  task automatic predict();
    exp_valid = req_valid;
    exp_v = 6'b0;
    exp_class = 0;
    exp_idx = 0;
    exp_tag = "R10";
    if (!req_valid) return;
    exp_idx = req_crm;
    if (!(req_op0 == 2 && req_op1 == 0 && req_crn == 0 && req_op2 == 5)) begin
      exp_v = 6'b100000; exp_tag = "R1"; return;
    end
    if (int'(req_crm) >= NBP) begin exp_v = 6'b010000; exp_tag = "R2"; return; end
    if (req_el == 0) begin exp_v = 6'b010000; exp_tag = "R3"; return; end
    if (req_el == 1) begin
      if (el2_on && el2_64 && (req_write ? fgt_write : fgt_read) && (!el3_have || fgt_en)) begin
        exp_v = 6'b001000; exp_class = 6'h18; exp_tag = "R4"; return;
      end
      if (el2_on && el2_64 && (hyp_tde || hyp_tda)) begin
        exp_v = 6'b001000; exp_class = 6'h18; exp_tag = "R5"; return;
      end
    end
    if (req_el != 3 && el3_have && el3_64 && mon_tda) begin
      exp_v = 6'b000100; exp_class = 6'h18; exp_tag = "R6"; return;
    end
    if (el1_64 && !os_lock && halt_ok && ext_tda) begin
      exp_v = 6'b000010; exp_tag = "R7"; return;
    end
    exp_v = 6'b000001; exp_tag = "R8";
  endtask

  task automatic compare(input string tag);
    logic [5:0] got;
    got = {res_foreign, res_undef, res_trap2, res_trap3, res_halt, res_access};
    checks++;
    if (got !== exp_v || res_valid !== exp_valid || res_class !== exp_class || res_index !== exp_idx) begin
      errors++;
      $display("FAIL %s: valid/verdict/class/index got %b/%b/%h/%0d expected %b/%b/%h/%0d",
               tag, res_valid, got, res_class, res_index, exp_valid, exp_v, exp_class, exp_idx);
    end
    if (exp_class != 0) begin
      checks++;
      if (res_class !== 6'h18) begin
        errors++;
        $display("FAIL R9: class got %h expected 18", res_class);
      end
    end
  endtask

  task automatic randomize_inputs();
    req_valid = ($urandom_range(4) != 0);
    req_el = 2'($urandom);  req_write = 1'($urandom);
    if ($urandom_range(3) != 0) begin
      req_op0 = 2; req_op1 = 0; req_crn = 0; req_op2 = 5;
    end else begin
      req_op0 = 2'($urandom); req_op1 = 3'($urandom);
      req_crn = 4'($urandom); req_op2 = 3'($urandom);
    end
    req_crm = 4'($urandom);
    {fgt_read, fgt_write, fgt_en, hyp_tde, hyp_tda, mon_tda, ext_tda} = 7'($urandom);
    {el2_on, el2_64, el3_have, el3_64, el1_64, os_lock, halt_ok} = 7'($urandom);
  endtask

  initial begin
    #40000;
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    req_valid = 1;
    req_op0 = 2; req_op2 = 5;
    repeat (3) @(negedge clk);
    exp_valid = 0; exp_v = 0; exp_class = 0; exp_idx = 0;
    compare("R11");
    @(negedge clk);
    req_valid = 0;
    rst_n = 1;
    predict();
    // directed: write at level 1 with only the write fine-grained bit set
    @(negedge clk); compare(exp_tag);
    req_valid = 1; req_el = 1; req_write = 1; req_crm = 3;
    el2_on = 1; el2_64 = 1; fgt_write = 1; fgt_read = 0;
    predict();
    @(negedge clk); compare("R4");
    // same at level 2: the fine-grained bit has no effect
    req_el = 2; hyp_tda = 1;
    predict();
    @(negedge clk); compare("R8");
    // read with only the write bit: falls to the hypervisor trap
    req_el = 1; req_write = 0;
    predict();
    @(negedge clk); compare("R5");
    // index at the boundary
    req_crm = 4'(NBP);
    predict();
    @(negedge clk); compare("R2");
    req_crm = 4'(NBP - 1); req_el = 3; mon_tda = 1; el3_have = 1; el3_64 = 1;
    predict();
    @(negedge clk); compare("R8");
    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      predict();
      @(negedge clk);
      compare(exp_tag);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule